// File: doc/BRIEF.md
# Hitless Function Switch-Over Sequencer

This block is the control state machine that moves traffic from the processing region now in service to an idle spare region without dropping data. A host raises a request. The sequencer then waits for an external loader to report that the new function has been placed into the spare region, and traffic keeps flowing through the region in service during that wait. Once the loader reports done, the sequencer tells the edge interfaces to hold traffic. It waits for the aggregated flag saying that nothing is left in flight, and then rewrites the router table entries over an AXI4-lite write channel. Finally it lets traffic go again and swaps the roles of the two regions.

Traffic is held only for the few cycles that the table rewrite takes. Each table entry maps one destination to one output port and is 8 bytes wide, so it is sent as two 32-bit writes. The number of entries rewritten is chosen per request, up to the size of a router table. If the held flag never arrives, a timeout abandons the attempt and releases traffic. The roles are left unchanged in that case.

Top module: `hitless_switchover`

## Requirements
- R1: After reset, `state_o` is 0 (idle), `active_idx` is 0, and `hold_cmd`, `awvalid`, `wvalid`, `bready`, `done` and `refused` are all low.
- R2: A request in idle moves `state_o` to 1 (loading) on the next cycle. `hold_cmd` stays low for as long as `load_done` is low. On the cycle after `load_done` is seen in loading, `state_o` is 2 (holding) and `hold_cmd` is high.
- R3: While in holding, no table write is issued until `all_held` is seen high. On the cycle after that, `state_o` is 3 (writing).
- R4: For an entry count N, exactly 2N writes are issued in ascending order. For entry k, the first write goes to `TBL_BASE + 8k` with data `dest_base + k`, zero-extended. The second goes to `TBL_BASE + 8k + 4`. Only one write is outstanding at a time (`state_o` is 4 while waiting for the response). `awaddr` and `wdata` hold steady until accepted.
- R5: On the cycle after the last write response, `state_o` is 0, `hold_cmd` is low, `active_idx` has toggled, and `done` is high for exactly one cycle.
- R6: The data of each second write is the output port of the region that becomes active, zero-extended: `port_r1` when `active_idx` was 0, otherwise `port_r0`. Ports and `dest_base` are captured at the accepted request.
- R7: A request made while `state_o` is not 0 raises `refused` in the same cycle and is dropped: the running sequence toggles `active_idx` only once and is not restarted.
- R8: If `all_held` stays low for `TIMEOUT` cycles in holding, `state_o` becomes 5 (error) for one cycle with `hold_cmd` low. It then returns to 0. No write is issued, `done` stays low and `active_idx` is unchanged.
- R9: An entry count of 0 is treated as 1, and a count above `MAX_ENTRIES` is treated as `MAX_ENTRIES`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Switch-over request from the host |
| refused | output | 1 | Request dropped because a sequence is running |
| load_done | input | 1 | Loader has finished placing the new function |
| hold_cmd | output | 1 | High: edge interfaces hold traffic; low: traffic flows |
| all_held | input | 1 | Aggregated flag: all traffic is held, none in flight |
| n_entries | input | CNT_W | Number of table entries to rewrite |
| dest_base | input | DEST_W | First destination identifier rewritten |
| port_r0 | input | PORT_W | Output port reaching region 0 |
| port_r1 | input | PORT_W | Output port reaching region 1 |
| awvalid | output | 1 | Write address valid |
| awready | input | 1 | Write address ready |
| awaddr | output | ADDR_W | Write address |
| wvalid | output | 1 | Write data valid |
| wready | input | 1 | Write data ready |
| wdata | output | 32 | Write data |
| bvalid | input | 1 | Write response valid |
| bready | output | 1 | Write response ready |
| state_o | output | 3 | Current state code |
| active_idx | output | 1 | Index of the region in service |
| done | output | 1 | One-cycle pulse when a switch-over completes |

## Verification
The bench builds the block with `MAX_ENTRIES` = 32 and `TIMEOUT` = 20. This lets it sweep every entry count from 1 to 32, plus 0 and 40 for the clamping, under three AXI stall patterns. It also makes the timeout reachable in a few tens of cycles, so the error path can be timed exactly. Each sweep step varies the loader and flag latencies, checks the full address and data of every write, and checks that the active index alternates. Separate passes cover a refused request and recovery after a timeout.

// File: rtl/hitless_switchover.sv
module hitless_switchover #(
  parameter int ADDR_W      = 32,
  parameter int DEST_W      = 16,
  parameter int PORT_W      = 8,
  parameter int MAX_ENTRIES = 32,
  parameter int TIMEOUT     = 1024,
  parameter logic [ADDR_W-1:0] TBL_BASE = '0,
  localparam int CNT_W = $clog2(MAX_ENTRIES + 1),
  localparam int IDX_W = (MAX_ENTRIES > 1) ? $clog2(MAX_ENTRIES) : 1,
  localparam int TMR_W = $clog2(TIMEOUT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  output logic              refused,
  input  logic              load_done,
  output logic              hold_cmd,
  input  logic              all_held,
  input  logic [CNT_W-1:0]  n_entries,
  input  logic [DEST_W-1:0] dest_base,
  input  logic [PORT_W-1:0] port_r0,
  input  logic [PORT_W-1:0] port_r1,
  output logic              awvalid,
  input  logic              awready,
  output logic [ADDR_W-1:0] awaddr,
  output logic              wvalid,
  input  logic              wready,
  output logic [31:0]       wdata,
  input  logic              bvalid,
  output logic              bready,
  output logic [2:0]        state_o,
  output logic              active_idx,
  output logic              done
);

  typedef enum logic [2:0] {
    S_IDLE = 3'd0, S_LOAD = 3'd1, S_HOLD = 3'd2,
    S_WR   = 3'd3, S_RESP = 3'd4, S_ERR  = 3'd5
  } st_t;

  st_t               st;
  logic [IDX_W-1:0]  ent, last;
  logic              half, aw_ok, w_ok, act, done_q;
  logic [TMR_W-1:0]  tmr;
  logic [DEST_W-1:0] dest_q;
  logic [PORT_W-1:0] port_q;
  logic [CNT_W-1:0]  n_clamp;

  assign n_clamp = (n_entries == '0) ? CNT_W'(1) :
                   (n_entries > CNT_W'(MAX_ENTRIES)) ? CNT_W'(MAX_ENTRIES) : n_entries;

  wire aw_fire = awvalid && awready;
  wire w_fire  = wvalid && wready;

  assign refused    = req && (st != S_IDLE);
  assign hold_cmd   = (st == S_HOLD) || (st == S_WR) || (st == S_RESP);
  assign awvalid    = (st == S_WR) && !aw_ok;
  assign wvalid     = (st == S_WR) && !w_ok;
  assign bready     = (st == S_RESP);
  assign awaddr     = TBL_BASE + ADDR_W'({ent, half, 2'b00});
  assign wdata      = half ? 32'(port_q) : 32'(dest_q + DEST_W'(ent));
  assign state_o    = st;
  assign active_idx = act;
  assign done       = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      ent    <= '0;
      last   <= '0;
      half   <= 1'b0;
      aw_ok  <= 1'b0;
      w_ok   <= 1'b0;
      act    <= 1'b0;
      done_q <= 1'b0;
      tmr    <= '0;
      dest_q <= '0;
      port_q <= '0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (req) begin
          st     <= S_LOAD;
          last   <= IDX_W'(n_clamp - CNT_W'(1));
          dest_q <= dest_base;
          port_q <= act ? port_r0 : port_r1;
        end
        S_LOAD: if (load_done) begin
          st  <= S_HOLD;
          tmr <= '0;
        end
        S_HOLD: begin
          if (all_held) begin
            st   <= S_WR;
            ent  <= '0;
            half <= 1'b0;
          end else if (tmr == TMR_W'(TIMEOUT - 1)) begin
            st <= S_ERR;
          end else begin
            tmr <= tmr + TMR_W'(1);
          end
        end
        S_WR: begin
          if ((aw_ok || aw_fire) && (w_ok || w_fire)) begin
            st    <= S_RESP;
            aw_ok <= 1'b0;
            w_ok  <= 1'b0;
          end else begin
            aw_ok <= aw_ok || aw_fire;
            w_ok  <= w_ok || w_fire;
          end
        end
        S_RESP: if (bvalid) begin
          if (half && ent == last) begin
            st     <= S_IDLE;
            act    <= ~act;
            done_q <= 1'b1;
          end else begin
            st   <= S_WR;
            half <= ~half;
            if (half) ent <= ent + IDX_W'(1);
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r2_hold_after_load: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_cmd) |-> $past(load_done));
  a_r3_no_write_before_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_HOLD && !all_held) |=> !awvalid && !wvalid);
  a_r4_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (awvalid && !awready) |=> awvalid && $stable(awaddr));
  a_r4_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (wvalid && !wready) |=> wvalid && $stable(wdata));
  a_r4_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    bready |-> !awvalid && !wvalid);
  a_r5_swap_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (active_idx != $past(active_idx)) && !hold_cmd);
  a_r8_error_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ERR) |=> (st == S_IDLE) && $stable(active_idx) && !done);

endmodule

// File: tb/sim_hitless_switchover.sv
module sim_hitless_switchover;
  localparam int MAXE = 32;
  localparam int TMO  = 20;
  localparam logic [31:0] BASE = 32'h4000_0000;

  logic clk = 1'b0, rst_n = 1'b0, req = 1'b0, load_done = 1'b0, all_held = 1'b0;
  logic [5:0] n_entries = '0;
  logic [15:0] dest_base = '0;
  logic [7:0] port_r0 = '0, port_r1 = '0;
  logic awready = 1'b0, wready = 1'b0, bvalid = 1'b0;
  logic refused, hold_cmd, awvalid, wvalid, bready, active_idx, done;
  logic [31:0] awaddr, wdata;
  logic [2:0] state_o;

  always #5 clk = ~clk;

  hitless_switchover #(.ADDR_W(32), .DEST_W(16), .PORT_W(8), .MAX_ENTRIES(MAXE),
                       .TIMEOUT(TMO), .TBL_BASE(BASE)) u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .refused(refused), .load_done(load_done),
    .hold_cmd(hold_cmd), .all_held(all_held), .n_entries(n_entries), .dest_base(dest_base),
    .port_r0(port_r0), .port_r1(port_r1), .awvalid(awvalid), .awready(awready),
    .awaddr(awaddr), .wvalid(wvalid), .wready(wready), .wdata(wdata), .bvalid(bvalid),
    .bready(bready), .state_o(state_o), .active_idx(active_idx), .done(done));

  int checks = 0, fails = 0;
  int stall = 0, cyc = 0, na = 0, nd = 0, bdly = 0;
  bit got_aw = 0, got_w = 0, b_fire = 0;
  logic [31:0] addr_log [64];
  logic [31:0] data_log [64];

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (b_fire) begin bvalid = 1'b0; b_fire = 0; end
    if (got_aw && got_w && !bvalid) begin
      if (bdly >= stall) begin bvalid = 1'b1; got_aw = 0; got_w = 0; bdly = 0; end
      else bdly++;
    end
    awready = awvalid && ((cyc % (stall + 1)) == 0);
    wready  = wvalid && (((cyc + 1) % (stall + 1)) == 0);
    if (awvalid && awready) begin got_aw = 1; if (na < 64) addr_log[na] = awaddr; na++; end
    if (wvalid && wready)   begin got_w = 1;  if (nd < 64) data_log[nd] = wdata;  nd++; end
    if (bvalid && bready) b_fire = 1;
  end

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_done(output bit seen);
    seen = 0;
    for (int i = 0; i < 3000 && !seen; i++) begin
      step();
      if (done) seen = 1;
    end
  endtask

  task automatic do_switch(input int n, input int st_in, input int load_lat,
                           input int flag_lat, input bit try_busy);
    bit seen;
    bit old_act;
    int neff;
    logic [7:0] exp_port;
    neff = (n == 0) ? 1 : ((n > MAXE) ? MAXE : n);
    stall = st_in; na = 0; nd = 0;
    n_entries = 6'(n);
    dest_base = 16'h0100 + 16'(n * 3);
    port_r0 = 8'h11 + 8'(n);
    port_r1 = 8'h80 + 8'(n);
    old_act = active_idx;
    exp_port = old_act ? port_r0 : port_r1;
    req = 1'b1;
    step();
    req = 1'b0;
    check(state_o == 3'd1, "R2 enter loading", state_o, 1);
    for (int i = 0; i < load_lat; i++) begin
      if (try_busy && i == 0) begin
        req = 1'b1; #1;
        check(refused == 1'b1, "R7 refused while busy", refused, 1);
        port_r0 = 8'hEE; port_r1 = 8'hEE; dest_base = 16'hBEEF;
      end
      check(hold_cmd == 1'b0, "R2 no hold before load done", hold_cmd, 0);
      step();
      req = 1'b0;
    end
    if (try_busy) check(state_o == 3'd1, "R7 still loading after refusal", state_o, 1);
    load_done = 1'b1;
    step();
    load_done = 1'b0;
    check(state_o == 3'd2 && hold_cmd, "R2 holding after load done", {state_o, hold_cmd}, {3'd2, 1'b1});
    for (int i = 0; i < flag_lat; i++) begin
      check(!awvalid && !wvalid, "R3 no write before held flag", awvalid, 0);
      step();
    end
    all_held = 1'b1;
    step();
    check(state_o == 3'd3, "R3 writing after held flag", state_o, 3);
    wait_done(seen);
    all_held = 1'b0;
    check(seen, "R5 done pulse seen", seen, 1);
    check(active_idx == !old_act, "R5 active toggled", active_idx, !old_act);
    check(!hold_cmd && state_o == 3'd0, "R5 released and idle", {state_o, hold_cmd}, 0);
    check(na == 2 * neff && nd == 2 * neff, (n == 0 || n > MAXE) ? "R9 clamped write count" : "R4 write count", na, 2 * neff);
    for (int k = 0; k < neff && na == 2 * neff && nd == 2 * neff; k++) begin
      check(addr_log[2*k] == BASE + 32'(8 * k), "R4 low word address", addr_log[2*k], BASE + 32'(8 * k));
      check(addr_log[2*k+1] == BASE + 32'(8 * k + 4), "R4 high word address", addr_log[2*k+1], BASE + 32'(8 * k + 4));
      check(data_log[2*k] == 32'(16'h0100 + 16'(n * 3) + 16'(k)), "R4 destination data",
            data_log[2*k], 32'(16'h0100 + 16'(n * 3) + 16'(k)));
      check(data_log[2*k+1] == 32'(exp_port), "R6 new active port data", data_log[2*k+1], exp_port);
    end
    step();
    check(done == 1'b0, "R5 done lasts one cycle", done, 0);
    if (try_busy) check(state_o == 3'd0, "R7 refused request not started", state_o, 0);
  endtask

  initial begin
    int cnt;
    bit old_act;
    step(4);
    check(state_o == 3'd0, "R1 reset state", state_o, 0);
    check(active_idx == 1'b0, "R1 reset active", active_idx, 0);
    check(!hold_cmd && !awvalid && !wvalid && !bready && !done && !refused,
          "R1 reset outputs low", {hold_cmd, awvalid, wvalid, bready, done, refused}, 0);
    rst_n = 1'b1;
    step(2);
    check(state_o == 3'd0 && !hold_cmd, "R1 idle after reset", state_o, 0);

    for (int s = 0; s < 3; s++)
      for (int n = 1; n <= MAXE; n++)
        do_switch(n, s, (n + s) % 4, (n * 7 + s) % 5, 1'b0);
    do_switch(0, 1, 2, 1, 1'b0);
    do_switch(40, 2, 1, 3, 1'b0);
    do_switch(5, 0, 3, 2, 1'b1);

    old_act = active_idx;
    na = 0; nd = 0;
    req = 1'b1; step(); req = 1'b0;
    load_done = 1'b1; step(); load_done = 1'b0;
    cnt = 0;
    while (state_o == 3'd2 && cnt < 200) begin cnt++; step(); end
    check(cnt == TMO, "R8 timeout length", cnt, TMO);
    check(state_o == 3'd5 && !hold_cmd, "R8 error state releases", {state_o, hold_cmd}, {3'd5, 1'b0});
    step();
    check(state_o == 3'd0, "R8 back to idle", state_o, 0);
    check(active_idx == old_act && !done, "R8 roles unchanged", active_idx, old_act);
    check(na == 0 && nd == 0, "R8 no writes on timeout", na, 0);
    do_switch(3, 1, 1, 1, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule